// File: doc/BRIEF.md
# Floating-point register immediate-offset load unit

This unit executes one floating-point register load instruction at a time. On a `start` pulse it decodes the 32-bit instruction word and forms an effective address from a base register, or from the word-aligned PC, plus or minus a scaled 8-bit immediate. It then reads 16, 32 or 64 bits through a single-outstanding 32-bit memory port and writes the result to a scalar register file that is addressed either as 32-bit single or as 64-bit double registers.

The surrounding pipeline evaluates the condition and presents the result as `cond_pass`. It also says whether half-precision is supported and which byte order is in force. The unit reports completion with a one-cycle `done` pulse. In that same cycle it either writes the register file once, flags the instruction as undefined, or does nothing if the condition failed. `busy` is high from the cycle after `start` is accepted until the cycle after `done`. A `start` pulse that arrives while `busy` is high is not accepted.

Instruction fields used: U = bit 23, D = bit 22, Rn = bits 19:16, Vd = bits 15:12, size = bits 9:8, imm8 = bits 7:0. The condition field (bits 31:28) and the remaining bits are not examined.

Top module: `fpld_unit`

## Requirements
- R1: The size field picks the element: 01 is 16 bits, 10 is 32 bits and 11 is 64 bits. `rf_width` carries the same 2-bit code on the write.
- R2: Size 00, or size 01 while `fp16_en` is low, gives `done` with `undef` high, no memory request and no register write. This holds whatever the value of `cond_pass`.
- R3: The immediate is zero-extended. It is multiplied by 2 for 16-bit loads (offset 0 to 510) and by 4 for 32-bit and 64-bit loads (offset 0 to 1020).
- R4: With U=1 the address is base plus offset. With U=0 it is base minus offset, modulo 2^32.
- R5: For 16-bit and 32-bit loads `rf_idx` = {Vd, D}. For 64-bit loads `rf_idx` = {D, Vd}.
- R6: When Rn is 15 the base is `pc_val` with bits 1:0 cleared, and `base_val` is ignored.
- R7: A 16-bit load issues one request with `mem_req_half`=1. It writes `mem_rsp_data[15:0]` into `rf_wdata[15:0]` with bits 63:16 zero. A 32-bit load issues one request with `mem_req_half`=0 and writes {32'b0, word}.
- R8: A 64-bit load issues two word requests, to the address and then to address+4. With `big_end`=1 `rf_wdata` = {first, second}. With `big_end`=0 it is {second, first}.
- R9: A legal 16-bit load whose condition field is not 1110 is executed as a normal load when `cond_pass` is high.
- R10: A legal instruction with `cond_pass` low gives `done` in the cycle after `start` is accepted, with no request, no write and `undef` low.
- R11: A request holds `mem_req_valid` and `mem_req_addr` until `mem_req_ready`. No new request is made until the response has returned.
- R12: Every completed load raises `rf_we` exactly once, in the `done` cycle, one cycle after the last response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction valid; accepted only while not busy |
| insn | input | 32 | Instruction word |
| cond_pass | input | 1 | Condition check result |
| fp16_en | input | 1 | Half-precision loads supported |
| base_val | input | 32 | Value of the base register |
| pc_val | input | 32 | Current PC |
| big_end | input | 1 | 1 = big-endian word order for 64-bit loads |
| busy | output | 1 | Instruction in flight |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | 32 | Read byte address |
| mem_req_half | output | 1 | 1 = 2-byte read, 0 = 4-byte read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data (halfword in bits 15:0) |
| rf_we | output | 1 | Register-file write strobe |
| rf_idx | output | 5 | Destination register index |
| rf_width | output | 2 | Write width code: 01 = 16, 10 = 32, 11 = 64 bits |
| rf_wdata | output | 64 | Write data |
| done | output | 1 | Instruction complete, one cycle |
| undef | output | 1 | Undefined instruction, valid with done |

## Verification
A skipped or undefined instruction must show `done` at the first falling edge after the rising edge that accepted `start`, and the bench requires exactly that count. A load's first request appears in the cycle after acceptance. Its `done` and write come one cycle after the final response. The memory model adds random ready stalls and response delays, so the bench waits for `done` at falling edges and only then compares the write fields and data. Request addresses and sizes are recorded at each accepted handshake and compared after `done`. This also confirms that no request was made for skipped and undefined instructions.

// File: rtl/fpld_pkg.sv
package fpld_pkg;

  // element size code, also the register-file width code
  typedef enum logic [1:0] {
    ESZ_NONE = 2'b00,
    ESZ_HALF = 2'b01,
    ESZ_WORD = 2'b10,
    ESZ_DBL  = 2'b11
  } esz_t;

  localparam int unsigned RN_W   = 4;
  localparam int unsigned VD_W   = 4;
  localparam int unsigned IMM_W  = 8;
  localparam int unsigned IDX_W  = VD_W + 1;
  localparam logic [RN_W-1:0] RN_PC = 4'd15;

  typedef struct packed {
    logic              illegal;
    esz_t              esz;
    logic              add;
    logic [RN_W-1:0]   rn;
    logic [IDX_W-1:0]  dst;
    logic [IMM_W-1:0]  imm;
  } dec_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_FIN  = 2'd3
  } st_t;

endpackage

// File: rtl/fpld_decode.sv
module fpld_decode
  import fpld_pkg::*;
(
  input  logic [31:0] insn,
  input  logic        fp16_en,
  output dec_t        dec
);
  logic [1:0]       sz;
  logic             dbit;
  logic [VD_W-1:0]  vd;
  logic             unused_bits;

  assign sz   = insn[9:8];
  assign dbit = insn[22];
  assign vd   = insn[15:12];
  // condition field and fixed opcode bits are not examined here
  assign unused_bits = ^{insn[31:24], insn[21:20], insn[11:10]};

  always_comb begin
    dec.esz     = esz_t'(sz);
    dec.add     = insn[23];
    dec.rn      = insn[19:16];
    dec.imm     = insn[7:0];
    dec.illegal = (sz == 2'b00) || ((sz == 2'b01) && !fp16_en);
    if (sz == 2'b11) dec.dst = {dbit, vd};
    else             dec.dst = {vd, dbit};
  end
endmodule

// File: rtl/fpld_agen.sv
module fpld_agen
  import fpld_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0]    base_val,
  input  logic [AW-1:0]    pc_val,
  input  logic [RN_W-1:0]  rn,
  input  logic [IMM_W-1:0] imm,
  input  logic             half,
  input  logic             add,
  output logic [AW-1:0]    addr
);
  localparam int unsigned PADH = AW - IMM_W - 1;
  localparam int unsigned PADW = AW - IMM_W - 2;

  logic [AW-1:0] base;
  logic [AW-1:0] off;

  always_comb begin
    if (rn == RN_PC) base = {pc_val[AW-1:2], 2'b00};
    else             base = base_val;
    if (half) off = {{PADH{1'b0}}, imm, 1'b0};
    else      off = {{PADW{1'b0}}, imm, 2'b00};
    if (add)  addr = base + off;
    else      addr = base - off;
  end
endmodule

// File: rtl/fpld_assemble.sv
module fpld_assemble
  import fpld_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  esz_t            esz,
  input  logic            big,
  input  logic [DW-1:0]   first,
  input  logic [DW-1:0]   last,
  output logic [2*DW-1:0] data
);
  localparam int unsigned HW = DW / 2;

  always_comb begin
    case (esz)
      ESZ_HALF: data = {{(DW + HW){1'b0}}, last[HW-1:0]};
      ESZ_WORD: data = {{DW{1'b0}}, last};
      ESZ_DBL:  data = big ? {first, last} : {last, first};
      default:  data = '0;
    endcase
  end
endmodule

// File: rtl/fpld_seq.sv
module fpld_seq
  import fpld_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cond_pass,
  input  dec_t              dec,
  input  logic [AW-1:0]     addr0,
  input  logic              big_end,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  output logic              mem_req_half,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [1:0]        rf_width,
  output logic [2*DW-1:0]   rf_wdata,
  output logic              done,
  output logic              undef
);
  localparam logic [AW-1:0] WSTEP = AW'(DW / 8);

  st_t              st_q,    st_d;
  logic [AW-1:0]    addr_q,  addr_d;
  logic             beat_q,  beat_d;
  esz_t             esz_q,   esz_d;
  logic [IDX_W-1:0] dst_q,   dst_d;
  logic             big_q,   big_d;
  logic [DW-1:0]    w0_q,    w0_d;
  logic [2*DW-1:0]  data_q,  data_d;
  logic             undef_q, undef_d;
  logic             load_q,  load_d;
  logic             en_cmd, en_w0, en_data, en_addr;
  logic [2*DW-1:0]  asm_data;

  fpld_assemble #(.DW(DW)) u_asm (
    .esz   (esz_q),
    .big   (big_q),
    .first (w0_q),
    .last  (mem_rsp_data),
    .data  (asm_data)
  );

  always_comb begin
    st_d    = st_q;
    en_cmd  = 1'b0;
    en_w0   = 1'b0;
    en_data = 1'b0;
    en_addr = 1'b0;
    addr_d  = addr_q;
    beat_d  = beat_q;
    undef_d = undef_q;
    load_d  = load_q;
    esz_d   = dec.esz;
    dst_d   = dec.dst;
    big_d   = big_end;
    w0_d    = mem_rsp_data;
    data_d  = asm_data;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          en_cmd  = 1'b1;
          en_addr = 1'b1;
          addr_d  = addr0;
          beat_d  = 1'b0;
          if (dec.illegal) begin
            undef_d = 1'b1;
            load_d  = 1'b0;
            st_d    = ST_FIN;
          end else if (!cond_pass) begin
            undef_d = 1'b0;
            load_d  = 1'b0;
            st_d    = ST_FIN;
          end else begin
            undef_d = 1'b0;
            load_d  = 1'b1;
            st_d    = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (mem_req_ready) st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          if ((esz_q == ESZ_DBL) && !beat_q) begin
            en_w0   = 1'b1;
            en_addr = 1'b1;
            addr_d  = addr_q + WSTEP;
            beat_d  = 1'b1;
            st_d    = ST_REQ;
          end else begin
            en_data = 1'b1;
            st_d    = ST_FIN;
          end
        end
      end
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      addr_q  <= '0;
      beat_q  <= 1'b0;
      esz_q   <= ESZ_NONE;
      dst_q   <= '0;
      big_q   <= 1'b0;
      w0_q    <= '0;
      data_q  <= '0;
      undef_q <= 1'b0;
      load_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (en_addr) begin
        addr_q <= addr_d;
        beat_q <= beat_d;
      end
      if (en_cmd) begin
        esz_q   <= esz_d;
        dst_q   <= dst_d;
        big_q   <= big_d;
        undef_q <= undef_d;
        load_q  <= load_d;
      end
      if (en_w0)   w0_q   <= w0_d;
      if (en_data) data_q <= data_d;
    end
  end

  assign busy          = (st_q != ST_IDLE);
  assign mem_req_valid = (st_q == ST_REQ);
  assign mem_req_addr  = addr_q;
  assign mem_req_half  = (esz_q == ESZ_HALF);
  assign done          = (st_q == ST_FIN);
  assign rf_we         = done && load_q;
  assign undef         = done && undef_q;
  assign rf_idx        = dst_q;
  assign rf_width      = esz_q;
  assign rf_wdata      = data_q;
endmodule

// File: rtl/fpld_unit.sv
module fpld_unit
  import fpld_pkg::*;
#(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       insn,
  input  logic              cond_pass,
  input  logic              fp16_en,
  input  logic [AW-1:0]     base_val,
  input  logic [AW-1:0]     pc_val,
  input  logic              big_end,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [AW-1:0]     mem_req_addr,
  output logic              mem_req_half,
  input  logic              mem_rsp_valid,
  input  logic [DW-1:0]     mem_rsp_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_idx,
  output logic [1:0]        rf_width,
  output logic [2*DW-1:0]   rf_wdata,
  output logic              done,
  output logic              undef
);
  dec_t          dec;
  logic [AW-1:0] addr0;

  fpld_decode u_dec (
    .insn    (insn),
    .fp16_en (fp16_en),
    .dec     (dec)
  );

  fpld_agen #(.AW(AW)) u_agen (
    .base_val (base_val),
    .pc_val   (pc_val),
    .rn       (dec.rn),
    .imm      (dec.imm),
    .half     (dec.esz == ESZ_HALF),
    .add      (dec.add),
    .addr     (addr0)
  );

  fpld_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .cond_pass     (cond_pass),
    .dec           (dec),
    .addr0         (addr0),
    .big_end       (big_end),
    .busy          (busy),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_req_half  (mem_req_half),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .rf_we         (rf_we),
    .rf_idx        (rf_idx),
    .rf_width      (rf_width),
    .rf_wdata      (rf_wdata),
    .done          (done),
    .undef         (undef)
  );
endmodule

// File: rtl/fpld_unit_chk.sv
module fpld_unit_chk #(
  parameter int unsigned AW = 32,
  parameter int unsigned DW = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            busy,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic [AW-1:0]   mem_req_addr,
  input logic            rf_we,
  input logic [1:0]      rf_width,
  input logic [2*DW-1:0] rf_wdata,
  input logic            done,
  input logic            undef
);
  // R11: a pending request holds its address until accepted
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R11: no back-to-back request while a response is outstanding
  p_one_outstanding_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_ready |=> !mem_req_valid);

  // R12: a write only happens in the completion cycle
  p_we_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> done);

  // R12: completion is a single-cycle pulse
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2: undefined never writes
  p_undef_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    undef |-> done && !rf_we);

  // R1: written width is always a legal code
  p_width_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> rf_width != 2'b00);

  // R7: half writes carry zero upper bits
  p_half_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we && (rf_width == 2'b01) |-> rf_wdata[2*DW-1:DW/2] == '0);

  // R10: requests only while an instruction is in flight
  p_req_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);
endmodule

bind fpld_unit fpld_unit_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .rf_we         (rf_we),
  .rf_width      (rf_width),
  .rf_wdata      (rf_wdata),
  .done          (done),
  .undef         (undef)
);

// File: tb/fpld_unit_tb.sv
module fpld_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [31:0] insn;
  logic        cond_pass, fp16_en, big_end;
  logic [31:0] base_val, pc_val;
  logic        busy, mem_req_valid, mem_req_ready, mem_req_half;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        rf_we, done, undef;
  logic [4:0]  rf_idx;
  logic [1:0]  rf_width;
  logic [63:0] rf_wdata;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;

  fpld_unit u_dut (.*);

  // memory model
  int          req_cnt;
  logic [31:0] log_addr [4];
  logic        log_half [4];
  logic        pend;
  int          dly;
  logic [31:0] paddr;

  function automatic logic [31:0] memf(input logic [31:0] a);
    return a * 32'h9E3779B1 + 32'h1234_5677;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= '0;
      pend          <= 1'b0;
      dly           <= 0;
      paddr         <= '0;
      req_cnt       <= 0;
    end else begin
      mem_req_ready <= ($urandom % 4) != 0;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        log_addr[req_cnt % 4] <= mem_req_addr;
        log_half[req_cnt % 4] <= mem_req_half;
        req_cnt <= req_cnt + 1;
        pend    <= 1'b1;
        dly     <= $urandom % 3;
        paddr   <= mem_req_addr;
      end else if (pend) begin
        if (dly == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= memf(paddr);
          pend          <= 1'b0;
        end else begin
          dly <= dly - 1;
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] cnd, input logic u,
      input logic d, input logic [1:0] sz, input logic [3:0] rn,
      input logic [3:0] vd, input logic [7:0] imm);
    return {cnd, 4'b1101, u, d, 2'b01, rn, vd, 2'b10, sz, imm};
  endfunction

  function automatic logic [31:0] exp_addr(input logic [31:0] w,
      input logic [31:0] b, input logic [31:0] pc);
    logic [31:0] base, off;
    base = (w[19:16] == 4'd15) ? {pc[31:2], 2'b00} : b;
    off  = (w[9:8] == 2'b01) ? {23'd0, w[7:0], 1'b0} : {22'd0, w[7:0], 2'b00};
    return w[23] ? base + off : base - off;
  endfunction

  task automatic run_op(input logic [31:0] w, input logic cp, input logic f16,
                        input logic [31:0] b, input logic [31:0] pc,
                        input logic be, input string tag);
    int          c0, waited;
    logic        x_undef, x_load;
    logic [31:0] a;
    logic [63:0] xd;
    logic [4:0]  xi;
    @(negedge clk);
    while (busy) @(negedge clk);
    c0 = req_cnt;
    insn = w; cond_pass = cp; fp16_en = f16; base_val = b; pc_val = pc;
    big_end = be; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    insn = $urandom; base_val = $urandom; pc_val = $urandom;
    waited = 0;
    while (!done && waited < 64) begin
      @(negedge clk);
      waited++;
    end
    x_undef = (w[9:8] == 2'b00) || (w[9:8] == 2'b01 && !f16);
    x_load  = !x_undef && cp;
    chk(done, tag, "done seen", {63'd0, done}, 64'd1);
    chk(undef == x_undef, x_undef ? "R2" : "R10", "undef", {63'd0, undef}, {63'd0, x_undef});
    chk(rf_we == x_load, x_load ? "R12" : "R2", "rf_we", {63'd0, rf_we}, {63'd0, x_load});
    if (!x_load) begin
      chk(waited == 0, "R10", "skip latency", waited, 0);
      chk(req_cnt == c0, x_undef ? "R2" : "R10", "requests", req_cnt - c0, 0);
    end else begin
      a  = exp_addr(w, b, pc);
      xi = (w[9:8] == 2'b11) ? {w[22], w[15:12]} : {w[15:12], w[22]};
      case (w[9:8])
        2'b01:   xd = {48'd0, memf(a)[15:0]};
        2'b10:   xd = {32'd0, memf(a)};
        default: xd = be ? {memf(a), memf(a + 4)} : {memf(a + 4), memf(a)};
      endcase
      chk(rf_width == w[9:8], "R1", "width", rf_width, w[9:8]);
      chk(rf_idx == xi, "R5", "index", rf_idx, xi);
      chk(rf_wdata == xd, (w[9:8] == 2'b11) ? "R8" : "R7", "data", rf_wdata, xd);
      chk(log_addr[c0 % 4] == a, "R3", "address", log_addr[c0 % 4], a);
      chk(log_half[c0 % 4] == (w[9:8] == 2'b01), "R7", "half flag",
          log_half[c0 % 4], (w[9:8] == 2'b01));
      if (w[9:8] == 2'b11) begin
        chk(req_cnt - c0 == 2, "R8", "beats", req_cnt - c0, 2);
        chk(log_addr[(c0 + 1) % 4] == a + 4, "R8", "second addr",
            log_addr[(c0 + 1) % 4], a + 4);
      end else begin
        chk(req_cnt - c0 == 1, "R11", "beats", req_cnt - c0, 1);
      end
    end
    @(negedge clk);
    chk(!rf_we && !done, "R12", "single write", {62'd0, rf_we, done}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; insn = '0; cond_pass = 1'b0; fp16_en = 1'b0;
    base_val = '0; pc_val = '0; big_end = 1'b0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !rf_we && !mem_req_valid && !undef, "R12", "reset state",
        {59'd0, busy, done, rf_we, mem_req_valid, undef}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // directed corners
    run_op(mk(4'hE, 1'b1, 1'b1, 2'b10, 4'd3, 4'h7, 8'd0),   1, 1, 32'h1000, 32'h0, 0, "R1");
    run_op(mk(4'hE, 1'b0, 1'b0, 2'b01, 4'd2, 4'hF, 8'd255), 1, 1, 32'h4000, 32'h0, 0, "R3");
    run_op(mk(4'hE, 1'b0, 1'b1, 2'b10, 4'd2, 4'h1, 8'd255), 1, 1, 32'h0000_0100, 32'h0, 0, "R4");
    run_op(mk(4'hE, 1'b1, 1'b0, 2'b10, 4'd15, 4'h2, 8'd4),  1, 1, 32'hDEAD_0000, 32'h8003, 0, "R6");
    run_op(mk(4'hE, 1'b1, 1'b1, 2'b11, 4'd5, 4'h9, 8'd8),   1, 1, 32'h2000, 32'h0, 1, "R8");
    run_op(mk(4'hE, 1'b1, 1'b1, 2'b11, 4'd5, 4'h9, 8'd8),   1, 1, 32'h2000, 32'h0, 0, "R8");
    run_op(mk(4'hE, 1'b1, 1'b0, 2'b00, 4'd1, 4'h0, 8'd1),   1, 1, 32'h2000, 32'h0, 0, "R2");
    run_op(mk(4'hE, 1'b1, 1'b0, 2'b01, 4'd1, 4'h0, 8'd1),   1, 0, 32'h2000, 32'h0, 0, "R2");
    run_op(mk(4'h0, 1'b1, 1'b1, 2'b01, 4'd1, 4'h3, 8'd9),   1, 1, 32'h2000, 32'h0, 0, "R9");
    run_op(mk(4'hE, 1'b1, 1'b0, 2'b10, 4'd1, 4'h3, 8'd9),   0, 1, 32'h2000, 32'h0, 0, "R10");

    // random mix
    for (int i = 0; i < 300; i++) begin
      logic [1:0] sz;
      logic [3:0] rn;
      sz = $urandom;
      rn = (($urandom % 5) == 0) ? 4'd15 : 4'($urandom);
      run_op(mk(4'($urandom), 1'($urandom), 1'($urandom), sz, rn, 4'($urandom), 8'($urandom)),
             ($urandom % 8) != 0, ($urandom % 5) != 0, $urandom, $urandom, 1'($urandom), "R1");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule